// File: doc/BRIEF.md
# Surround Matrix Control Register Bank

This block is the control front end of an analog surround matrix. It listens to a two-wire serial bus (SCL clock, SDA data), sampled with a fast system clock. It recognises its own device address and keeps the settings that the matrix needs: the surround mode, the two input attenuations, the effect level and four phase-shifter resistor choices. The block is write-only and never stretches the clock. Its only drive onto the bus is an open-drain pull of SDA low during acknowledge clocks.

After a START, the first byte is compared with the device address `1101 11S0`, where S is the level of the address-select pin. A match is acknowledged. Every byte after it is then acknowledged until STOP. The leading bits of each data byte choose the target register, so one transfer can write any number of settings in any order. A setting changes only once its byte has been fully received and its acknowledge clock has ended.

Top module: `surr_ctrl_top`

## Requirements
- R1: After reset the settings are: both attenuations 6'b111110, effect level 4'b1110, mode 2'b11 (off), and all four phase-shifter codes 2'b10. SDA is released.
- R2: After START, the address byte 0xDC (when addr_sel is 0) or 0xDE (when addr_sel is 1) is acknowledged: sda_pull_low is 1 while SCL is high during the ninth clock.
- R3: An address byte that does not match, including one with the last (read) bit set, is not acknowledged. All bytes up to the next START are then neither acknowledged nor written.
- R4: Once addressed, every data byte is acknowledged until STOP. After STOP, SDA stays released.
- R5: A data byte `0 s a5..a0` writes a5..a0 to the right attenuation when s=0 and to the left attenuation when s=1. The byte leaves every other setting unchanged.
- R6: A data byte `1 m1 m0 1 e3..e0` writes e3..e0 to the effect level and m1m0 to the mode (00 simulated, 01 music, 10 movie, 11 off). Neither attenuation changes.
- R7: A data byte `1 m1 m0 0 0 f c1 c0` writes c1c0 to phase shifter 3 when f=1 and to phase shifter 4 when f=0. `1 m1 m0 0 1 0 c1 c0` writes phase shifter 2, and `1 m1 m0 0 1 1 c1 c0` writes phase shifter 1. Each of these bytes also writes m1m0 to the mode.
- R8: The bytes 0xD1, 0xCC, 0xC9, 0xC4, 0xC2 sent in one transfer give mode 10, effect 0001, PS1=00, PS2=01, PS3=00 and PS4=10.
- R9: A byte cut short by STOP or START changes no setting.
- R10: A repeated START restarts address matching, whether or not the slave was addressed before it.
- R11: No setting changes before the falling SCL edge that ends its byte's acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| addr_sel | input | 1 | Address-select pin, bit 1 of the device address |
| sda_pull_low | output | 1 | 1 = pull SDA low (open-drain enable) |
| mode | output | 2 | Surround mode: 00 sim, 01 music, 10 movie, 11 off |
| att_right | output | 6 | Right input attenuation code |
| att_left | output | 6 | Left input attenuation code |
| effect_lvl | output | 4 | Effect level code (step below -6 dB) |
| ps1_sel | output | 2 | Phase shifter 1 resistor code |
| ps2_sel | output | 2 | Phase shifter 2 resistor code |
| ps3_sel | output | 2 | Phase shifter 3 resistor code |
| ps4_sel | output | 2 | Phase shifter 4 resistor code |

## Verification
A bit counter that slips, or a wrong protocol state, shows first at sda_pull_low. The acknowledge then appears one SCL clock early or late, or is missing, and the bench samples it in every ninth clock. A wrong decode, or a write committed too early, shows in the setting outputs within a few system clocks of the acknowledge edge. The settings are compared every cycle against a model, and the model changes only after that edge. A slave that still reacts after an address mismatch or a cut-short byte shows as a setting that moved while the model held still.

// File: rtl/surr_pkg.sv
package surr_pkg;
  localparam int ATT_W = 6;
  localparam int EFF_W = 4;
  localparam int PS_W  = 2;
  localparam int NUM_PS = 4;

  typedef enum logic [1:0] {
    MODE_SIM   = 2'b00,
    MODE_MUSIC = 2'b01,
    MODE_MOVIE = 2'b10,
    MODE_OFF   = 2'b11
  } surr_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_ADDR_ACK,
    RX_DATA,
    RX_DATA_ACK,
    RX_SKIP
  } rx_state_e;

  localparam logic [ATT_W-1:0] ATT_RST  = 6'b111110;
  localparam logic [EFF_W-1:0] EFF_RST  = 4'b1110;
  localparam logic [PS_W-1:0]  PS_RST   = 2'b10;
  localparam logic [5:0]       DEV_ADDR_HI = 6'b110111;
endpackage

// File: rtl/surr_line_sync.sv
module surr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev_q;

  assign raw = {scl_in, sda_in};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      assign chain_d = {chain_q[STAGES-2:0], raw[g]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
          prev_q[g] <= 1'b1;
        end else begin
          chain_q <= chain_d;
          prev_q[g] <= chain_q[STAGES-1];
        end
      end
      assign synced[g] = chain_q[STAGES-1];
    end
  endgenerate

  logic scl_now, sda_now, scl_was, sda_was;
  assign scl_now = synced[1];
  assign sda_now = synced[0];
  assign scl_was = prev_q[1];
  assign sda_was = prev_q[0];

  assign sda_s    = sda_now;
  assign start_p  = scl_now & scl_was & sda_was & ~sda_now;
  assign stop_p   = scl_now & scl_was & ~sda_was & sda_now;
  assign scl_rise = scl_now & ~scl_was;
  assign scl_fall = ~scl_now & scl_was;
endmodule

// File: rtl/surr_i2c_rx.sv
module surr_i2c_rx
  import surr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       addr_sel,
  output logic       sda_pull,
  output logic       wr_en,
  output logic [7:0] wr_byte
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(8);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic             pull_q, pull_d;
  logic             wr_q, wr_d;
  logic [7:0]       wb_q, wb_d;
  logic [7:0]       my_addr;

  assign my_addr = {DEV_ADDR_HI, addr_sel, 1'b0};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    pull_d  = pull_q;
    wr_d    = 1'b0;
    wb_d    = wb_q;
    if (start_p) begin
      state_d = RX_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_p) begin
      state_d = RX_IDLE;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        RX_ADDR, RX_DATA: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (state_q == RX_DATA) begin
              pull_d  = 1'b1;
              state_d = RX_DATA_ACK;
            end else if (sh_q == my_addr) begin
              pull_d  = 1'b1;
              state_d = RX_ADDR_ACK;
            end else begin
              state_d = RX_SKIP;
            end
          end
        end
        RX_ADDR_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            state_d = RX_DATA;
            cnt_d   = '0;
          end
        end
        RX_DATA_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            state_d = RX_DATA;
            cnt_d   = '0;
            wr_d    = 1'b1;
            wb_d    = sh_q;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      pull_q  <= 1'b0;
      wr_q    <= 1'b0;
      wb_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      pull_q  <= pull_d;
      wr_q    <= wr_d;
      wb_q    <= wb_d;
    end
  end

  assign sda_pull = pull_q;
  assign wr_en    = wr_q;
  assign wr_byte  = wb_q;

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (state_q == RX_ADDR) && !sda_pull) else $error("start"); // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_pull) else $error("stop"); // R4
  AST_WRITE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(sda_pull)) else $error("write"); // R11
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_SKIP) |-> !sda_pull && !wr_en) else $error("skip"); // R3
endmodule

// File: rtl/surr_reg_bank.sv
module surr_reg_bank
  import surr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  output logic [1:0]       mode,
  output logic [ATT_W-1:0] att_right,
  output logic [ATT_W-1:0] att_left,
  output logic [EFF_W-1:0] effect_lvl,
  output logic [NUM_PS*PS_W-1:0] ps_sel
);
  logic [1:0]       mode_q, mode_d;
  logic [ATT_W-1:0] attr_q, attr_d, attl_q, attl_d;
  logic [EFF_W-1:0] eff_q, eff_d;
  logic [PS_W-1:0]  ps_q [NUM_PS];
  logic [PS_W-1:0]  ps_d [NUM_PS];
  logic [NUM_PS-1:0] ps_hit;

  logic is_ctrl, is_eff;
  assign is_ctrl = wr_byte[7];
  assign is_eff  = wr_byte[4];

  always_comb begin
    ps_hit = '0;
    if (wr_en && is_ctrl && !is_eff) begin
      unique case (wr_byte[3:2])
        2'b00: ps_hit[3] = 1'b1;
        2'b01: ps_hit[2] = 1'b1;
        2'b10: ps_hit[1] = 1'b1;
        default: ps_hit[0] = 1'b1;
      endcase
    end
  end

  always_comb begin
    mode_d = mode_q;
    attr_d = attr_q;
    attl_d = attl_q;
    eff_d  = eff_q;
    if (wr_en) begin
      if (!is_ctrl) begin
        if (wr_byte[6]) attl_d = wr_byte[ATT_W-1:0];
        else            attr_d = wr_byte[ATT_W-1:0];
      end else begin
        mode_d = wr_byte[6:5];
        if (is_eff) eff_d = wr_byte[EFF_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      attr_q <= ATT_RST;
      attl_q <= ATT_RST;
      eff_q  <= EFF_RST;
    end else begin
      mode_q <= mode_d;
      attr_q <= attr_d;
      attl_q <= attl_d;
      eff_q  <= eff_d;
    end
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PS; p++) begin : g_ps
      assign ps_d[p] = ps_hit[p] ? wr_byte[PS_W-1:0] : ps_q[p];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q[p] <= PS_RST;
        else        ps_q[p] <= ps_d[p];
      end
      assign ps_sel[p*PS_W +: PS_W] = ps_q[p];
    end
  endgenerate

  assign mode       = mode_q;
  assign att_right  = attr_q;
  assign att_left   = attl_q;
  assign effect_lvl = eff_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode) && $stable(att_right) && $stable(att_left)
               && $stable(effect_lvl) && $stable(ps_sel)) else $error("hold"); // R11
  AST_ATT_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_byte[7]) |=> $stable(mode) && $stable(effect_lvl) && $stable(ps_sel))
    else $error("att"); // R5
  AST_CTRL_KEEPS_ATT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte[7]) |=> $stable(att_right) && $stable(att_left)) else $error("ctrl"); // R6
  AST_ONE_SHIFTER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ps_hit)) else $error("ps"); // R7
endmodule

// File: rtl/surr_ctrl_top.sv
module surr_ctrl_top
  import surr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       addr_sel,
  output logic       sda_pull_low,
  output logic [1:0] mode,
  output logic [5:0] att_right,
  output logic [5:0] att_left,
  output logic [3:0] effect_lvl,
  output logic [1:0] ps1_sel,
  output logic [1:0] ps2_sel,
  output logic [1:0] ps3_sel,
  output logic [1:0] ps4_sel
);
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic sda_s, start_p, stop_p, scl_rise, scl_fall;
  logic wr_en;
  logic [7:0] wr_byte;
  logic [NUM_PS*PS_W-1:0] ps_sel;

  surr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  surr_i2c_rx u_rx (
    .clk(clk), .rst_n(rst_i), .sda_s(sda_s), .start_p(start_p),
    .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .addr_sel(addr_sel), .sda_pull(sda_pull_low),
    .wr_en(wr_en), .wr_byte(wr_byte)
  );

  surr_reg_bank u_bank (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_byte(wr_byte),
    .mode(mode), .att_right(att_right), .att_left(att_left),
    .effect_lvl(effect_lvl), .ps_sel(ps_sel)
  );

  assign ps1_sel = ps_sel[0*PS_W +: PS_W];
  assign ps2_sel = ps_sel[1*PS_W +: PS_W];
  assign ps3_sel = ps_sel[2*PS_W +: PS_W];
  assign ps4_sel = ps_sel[3*PS_W +: PS_W];
endmodule

// File: tb/tb_surr_ctrl_top.sv
module tb_surr_ctrl_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_pull_low;
  logic sda_line;
  logic [1:0] mode, ps1_sel, ps2_sel, ps3_sel, ps4_sel;
  logic [5:0] att_right, att_left;
  logic [3:0] effect_lvl;

  localparam int H = 16;

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull_low;

  surr_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .addr_sel(addr_sel), .sda_pull_low(sda_pull_low), .mode(mode),
    .att_right(att_right), .att_left(att_left), .effect_lvl(effect_lvl),
    .ps1_sel(ps1_sel), .ps2_sel(ps2_sel), .ps3_sel(ps3_sel), .ps4_sel(ps4_sel)
  );

  int checks = 0;
  int errors = 0;
  int settle = 0;
  bit cmp_on = 0;
  bit finished = 0;
  string cur_req = "R1";
  int phase = 0;   // 0 ignore, 1 expect address, 2 addressed

  logic [1:0] e_mode = 2'b11;
  logic [5:0] e_attr = 6'b111110, e_attl = 6'b111110;
  logic [3:0] e_eff = 4'b1110;
  logic [1:0] e_ps[4] = '{2'b10, 2'b10, 2'b10, 2'b10};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      if (settle > 0) settle--;
      else begin
        checks++;
        if (mode !== e_mode || att_right !== e_attr || att_left !== e_attl ||
            effect_lvl !== e_eff || ps1_sel !== e_ps[0] || ps2_sel !== e_ps[1] ||
            ps3_sel !== e_ps[2] || ps4_sel !== e_ps[3]) begin
          errors++;
          $display("FAIL %s actual=%h_%h_%h_%h_%h%h%h%h expected=%h_%h_%h_%h_%h%h%h%h",
                   cur_req, mode, att_right, att_left, effect_lvl,
                   ps1_sel, ps2_sel, ps3_sel, ps4_sel,
                   e_mode, e_attr, e_attl, e_eff, e_ps[0], e_ps[1], e_ps[2], e_ps[3]);
        end
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic model_apply(input logic [7:0] b);
    if (!b[7]) begin
      if (b[6]) e_attl = b[5:0]; else e_attr = b[5:0];
    end else begin
      e_mode = b[6:5];
      if (b[4]) e_eff = b[3:0];
      else case (b[3:2])
        2'b00: e_ps[3] = b[1:0];
        2'b01: e_ps[2] = b[1:0];
        2'b10: e_ps[1] = b[1:0];
        default: e_ps[0] = b[1:0];
      endcase
    end
    settle = 10;
  endtask

  task automatic bus_start();
    wclk(H/2); m_sda = 1'b1; wclk(H/2);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b0; wclk(H);
    m_scl = 1'b0;
    phase = 1;
  endtask

  task automatic bus_stop();
    wclk(H/2); m_sda = 1'b0; wclk(H/2);
    m_scl = 1'b1; wclk(H);
    m_sda = 1'b1; wclk(H);
    phase = 0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wclk(H/2); m_sda = b[i]; wclk(H/2);
      m_scl = 1'b1; wclk(H);
      m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    logic exp_ack;
    send_bits(b, 8);
    if (phase == 1) begin
      exp_ack = (b == {6'b110111, addr_sel, 1'b0});
      phase = exp_ack ? 2 : 0;
    end else if (phase == 2) exp_ack = 1'b1;
    else exp_ack = 1'b0;
    wclk(H/2); m_sda = 1'b1; wclk(H/2);
    m_scl = 1'b1; wclk(H/2);
    check(req, sda_pull_low, exp_ack);
    wclk(H/2);
    m_scl = 1'b0;
    if (exp_ack && (phase == 2) && !(b == {6'b110111, addr_sel, 1'b0} && settle < 0))
      ;
  endtask

  task automatic send_data(input logic [7:0] b, input string req);
    bit addressed;
    addressed = (phase == 2);
    cur_req = req;
    send_byte(b, req);
    if (addressed) model_apply(b);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(4);
    // R1 reset state
    check("R1", mode, 2'b11);
    check("R1", att_right, 6'b111110);
    check("R1", att_left, 6'b111110);
    check("R1", effect_lvl, 4'b1110);
    check("R1", {ps1_sel, ps2_sel, ps3_sel, ps4_sel}, 8'b10101010);
    check("R1", sda_pull_low, 0);
    cmp_on = 1;

    // R2 / R5: addressed with select low, attenuation writes
    cur_req = "R2";
    bus_start();
    send_byte(8'hDC, "R2");
    send_data(8'b00100100, "R5");
    send_data(8'b01000011, "R5");
    send_data(8'b01111111, "R4");
    bus_stop();
    check("R4", sda_pull_low, 0);

    // R8: five-byte sequence, covers R6 and R7
    bus_start();
    send_byte(8'hDC, "R2");
    send_data(8'hD1, "R8");
    send_data(8'hCC, "R8");
    send_data(8'hC9, "R8");
    send_data(8'hC4, "R8");
    send_data(8'hC2, "R8");
    bus_stop();
    wclk(12);
    check("R8", {mode, effect_lvl}, 6'b10_0001);
    check("R8", {ps1_sel, ps2_sel, ps3_sel, ps4_sel}, 8'b00_01_00_10);

    // R3: wrong address, then read bit
    cur_req = "R3";
    bus_start();
    send_byte(8'hDE, "R3");
    send_data(8'h00, "R3");
    send_data(8'hFF, "R3");
    bus_stop();
    bus_start();
    send_byte(8'hDD, "R3");
    send_data(8'h15, "R3");
    bus_stop();

    // R2 / R6 / R7 with select high
    addr_sel = 1'b1;
    wclk(4);
    bus_start();
    send_byte(8'hDE, "R2");
    send_data(8'b1001_1111, "R6");
    send_data(8'b1010_0111, "R7");
    send_data(8'b1110_1101, "R7");
    bus_stop();
    wclk(12);
    check("R6", effect_lvl, 4'b1111);
    check("R7", {mode, ps3_sel, ps2_sel}, 6'b11_11_01);

    // R9: partial byte cut by STOP, then by START
    cur_req = "R9";
    bus_start();
    send_byte(8'hDE, "R2");
    send_bits(8'h00, 4);
    bus_stop();
    bus_start();
    send_byte(8'hDE, "R2");
    send_bits(8'h40, 5);
    // R10: repeated start, matching again
    cur_req = "R10";
    bus_start();
    send_byte(8'hDE, "R10");
    send_data(8'b01010101, "R10");
    // R10: repeated start to a foreign address after being addressed
    bus_start();
    send_byte(8'hDC, "R10");
    send_data(8'b00000001, "R10");
    bus_stop();
    wclk(12);
    check("R10", att_left, 6'b010101);
    check("R9", att_right, 6'b100100);

    wclk(20);
    cmp_on = 0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule